// File: doc/BRIEF.md
# MDIO Management Frame Engine with Status Polling

This block is the host-side master for a PHY management bus. Software writes one 32-bit word to the frame register. The engine sends 32 preamble ones and then that word, most significant bit first, on a divided management clock. On a read it releases the data line for the turnaround and data fields and shifts in the 16 bits the PHY returns. It reports completion by setting bit 16 of the frame register. Software polls that bit until it reads as 1.

With polling enabled, the engine issues read frames to one configured PHY register without pause. It keeps the most recent value and accumulates which bits changed between successive reads. The changed bits, gated by a mask register, form an interrupt. In bit-bang mode, software drives the clock, data and output-enable pins directly from three one-bit registers. One of two input data lines is selected for sampling.

All registers share one simple port. Writes take effect at the clock edge. Read data is combinational from the address.

Register map, 3-bit address:

| Address | Register | Access |
|---------|----------|--------|
| 0 | frame | read/write |
| 1 | configuration | read/write |
| 2 | poll mask | read/write |
| 3 | poll status | read only, clears on read |
| 4 | bit-bang clock | read/write |
| 5 | bit-bang data | read/write |
| 6 | bit-bang output enable | read/write |

Top module: `mdio_mgmt_engine`

## Requirements
- R1: A frame write is accepted when the engine is idle and bit-bang mode is off. An accepted write is sent as 32 ones followed by frame bits 31 down to 0. Each bit lasts 2*HALF_DIV clocks. `mdc` is low for the first half of each bit and high for the second half. `mdioOut` changes only at a bit boundary. While idle, `mdc`, `mdioOut` and `mdioOe` are 0.
- R2: When frame bits 29:28 equal 2'b10, the frame is a read. For a read, `mdioOe` is low for the last 18 bit periods, which cover the turnaround and the data. For any other opcode, `mdioOe` stays high for all 64 bits.
- R3: On a read, the 16 data bits are sampled at the rising edges of `mdc`, MSB first. The sampled line is `mdioIn1` when configuration bit 0 is 1, and `mdioIn0` otherwise. At completion the 16 bits are placed in frame bits 15:0.
- R4: While a frame is in flight, frame bit 16 reads as written. At the end of the last bit it is set to 1. The other bits of a write frame are kept.
- R5: A frame-register write is ignored while a frame or a poll is in flight, and while bit-bang mode is on. Such a write leaves both the frame register and the serial stream unchanged.
- R6: Configuration bits 8 and 9 read the live levels of `mdioIn0` and `mdioIn1`.
- R7: Polling runs when configuration bit 1 is 1 and bit 2 is 0. It issues back-to-back read frames to PHY address cfg[14:10] and register address cfg[7:3]. Each completed poll stores the read value in status bits 31:16.
- R8: Status bits 15:0 accumulate the XOR between successive polled values. The first poll after polling is enabled sets no changed bit.
- R9: Reading the status register (address 3 with `regRd`) clears the changed bits. A change detected in the same cycle is kept.
- R10: `irq` is 1 when any changed bit has its mask bit (address 2, bits 15:0) at 0.
- R11: When configuration bit 2 is 1, `mdc`, `mdioOut` and `mdioOe` follow bit 0 of the registers at addresses 4, 5 and 6.
- R12: Reset values are: frame 0, configuration 0, mask 16'hFFFF, status 0, bit-bang registers 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; clears the poll changed bits at address 3 |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| mdioIn0 | input | 1 | Data input, line 0 |
| mdioIn1 | input | 1 | Data input, line 1 |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data output |
| mdioOe | output | 1 | Data output enable |
| irq | output | 1 | Masked poll-change interrupt |

## Verification
A write frame with mixed data checks the preamble, the bit order and that the host drives the line throughout. Read frames on each of the two lines, with differing values on the unselected line, show whether sampling uses the selected line. They also show whether the read data and the done flag land in the frame register.

Polling is run with a stable value, then a single change, then two changes that should accumulate. These cases separate first-poll behaviour, change accumulation, clear-on-read and masking. Frame writes during a frame, during a poll and during bit-bang show that a busy engine ignores them. A cycle model checks the pins on every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_W   = 32;
  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int TOTAL_BITS = PRE_BITS + FRAME_W;
  localparam int IDX_W     = $clog2(TOTAL_BITS);
  localparam int FIELD_W   = 5;
  localparam int ADDR_W    = 3;
  // first bit index where a read frame releases the line (turnaround)
  localparam int RD_RELEASE = PRE_BITS + 14;
  // first bit index of returned data
  localparam int RD_DATA    = PRE_BITS + 16;

  localparam logic [ADDR_W-1:0] ADDR_FRAME  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_BBCLK  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_BBDATA = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_BBOE   = 3'd6;

  typedef struct packed {
    logic             loadFrame;
    logic             loadPoll;
    logic             advance;
    logic             sample;
    logic             finish;
    logic             busy;
    logic             mdcHigh;
    logic [IDX_W-1:0] bitIdx;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameWrReq,
  input  logic         pollReq,
  input  logic         bbEn,
  output mdioStrobes_t strb
);
  localparam int BIT_CYC = 2 * HALF_DIV;
  localparam int PHW     = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [PHW-1:0]   phase;
  logic [IDX_W-1:0] bitIdx;
  logic             startFrame, startPoll, lastPhase, samplePhase;

  assign startFrame  = (state == ST_IDLE) && frameWrReq && !bbEn;
  assign startPoll   = (state == ST_IDLE) && !startFrame && pollReq && !bbEn;
  assign lastPhase   = (phase == PHW'(BIT_CYC - 1));
  assign samplePhase = (phase == PHW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (state == ST_IDLE) begin
      phase  <= '0;
      bitIdx <= '0;
      if (startFrame || startPoll) state <= ST_RUN;
    end else if (lastPhase) begin
      phase <= '0;
      if (bitIdx == LAST_IDX) state <= ST_IDLE;
      else bitIdx <= bitIdx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strb.loadFrame = startFrame;
    strb.loadPoll  = startPoll;
    strb.busy      = (state == ST_RUN);
    strb.advance   = strb.busy && lastPhase && (bitIdx != LAST_IDX);
    strb.finish    = strb.busy && lastPhase && (bitIdx == LAST_IDX);
    strb.sample    = strb.busy && samplePhase;
    strb.mdcHigh   = strb.busy && (phase >= PHW'(HALF_DIV));
    strb.bitIdx    = bitIdx;
  end

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (strb.bitIdx == $past(strb.bitIdx) + 1'b1)); // R1
  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.busy); // R1
endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  mdioStrobes_t       strb,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [FRAME_W-1:0] regWdata,
  output logic [FRAME_W-1:0] regRdata,
  input  logic               mdioIn0,
  input  logic               mdioIn1,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic               irq,
  output logic               frameWrReq,
  output logic               pollReq,
  output logic               bbEn
);
  localparam int SHIFT_W = PRE_BITS + FRAME_W;

  logic [FRAME_W-1:0] frameReg;
  logic               phySel, pollEn, bbEnR;
  logic [FIELD_W-1:0] pollRegAd, pollPhyAd;
  logic [DATA_W-1:0]  maskReg, pollBasic, pollChanged, rxShift;
  logic               pollValid;
  logic               bbClk, bbData, bbOe;
  logic [SHIFT_W-1:0] txShift;
  logic               curRead, curPoll;
  logic               inSel, clearRd, pollDone, engOe;
  logic [FRAME_W-1:0] pollWord;

  assign frameWrReq = regWr && (regAddr == ADDR_FRAME);
  assign pollReq    = pollEn && !bbEnR;
  assign bbEn       = bbEnR;
  assign inSel      = phySel ? mdioIn1 : mdioIn0;
  assign clearRd    = regRd && (regAddr == ADDR_STATUS);
  assign pollDone   = strb.finish && curPoll;
  assign pollWord   = {2'b01, 2'b10, pollPhyAd, pollRegAd, 2'b10, {DATA_W{1'b0}}};

  // line release window of a read frame
  assign engOe = strb.busy && !(curRead && (strb.bitIdx >= IDX_W'(RD_RELEASE)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      curRead <= 1'b0;
      curPoll <= 1'b0;
      rxShift <= '0;
    end else begin
      if (strb.loadFrame) begin
        txShift <= {{PRE_BITS{1'b1}}, regWdata};
        curRead <= (regWdata[29:28] == 2'b10);
        curPoll <= 1'b0;
      end else if (strb.loadPoll) begin
        txShift <= {{PRE_BITS{1'b1}}, pollWord};
        curRead <= 1'b1;
        curPoll <= 1'b1;
      end else if (strb.advance) begin
        txShift <= {txShift[SHIFT_W-2:0], 1'b0};
      end
      if (strb.sample && curRead && (strb.bitIdx >= IDX_W'(RD_DATA)))
        rxShift <= {rxShift[DATA_W-2:0], inSel};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (strb.loadFrame) begin
      frameReg <= regWdata;
    end else if (strb.finish && !curPoll) begin
      frameReg[16] <= 1'b1;
      if (curRead) frameReg[DATA_W-1:0] <= rxShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phySel <= 1'b0; pollEn <= 1'b0; bbEnR <= 1'b0;
      pollRegAd <= '0; pollPhyAd <= '0;
      maskReg <= '1;
      bbClk <= 1'b0; bbData <= 1'b0; bbOe <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_CFG: begin
          phySel    <= regWdata[0];
          pollEn    <= regWdata[1];
          bbEnR     <= regWdata[2];
          pollRegAd <= regWdata[7:3];
          pollPhyAd <= regWdata[14:10];
        end
        ADDR_MASK:   maskReg <= regWdata[DATA_W-1:0];
        ADDR_BBCLK:  bbClk   <= regWdata[0];
        ADDR_BBDATA: bbData  <= regWdata[0];
        ADDR_BBOE:   bbOe    <= regWdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollBasic   <= '0;
      pollChanged <= '0;
      pollValid   <= 1'b0;
    end else begin
      if (pollDone) begin
        pollBasic   <= rxShift;
        pollValid   <= 1'b1;
        pollChanged <= (clearRd ? '0 : pollChanged)
                     | (pollValid ? (pollBasic ^ rxShift) : '0);
      end else if (clearRd) begin
        pollChanged <= '0;
      end
      if (!pollEn) pollValid <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_FRAME:  regRdata = frameReg;
      ADDR_CFG:    regRdata = {17'b0, pollPhyAd, mdioIn1, mdioIn0, pollRegAd,
                               bbEnR, pollEn, phySel};
      ADDR_MASK:   regRdata = {{(FRAME_W-DATA_W){1'b0}}, maskReg};
      ADDR_STATUS: regRdata = {pollBasic, pollChanged};
      ADDR_BBCLK:  regRdata = {{(FRAME_W-1){1'b0}}, bbClk};
      ADDR_BBDATA: regRdata = {{(FRAME_W-1){1'b0}}, bbData};
      ADDR_BBOE:   regRdata = {{(FRAME_W-1){1'b0}}, bbOe};
      default:     regRdata = '0;
    endcase
  end

  assign mdc     = bbEnR ? bbClk  : strb.mdcHigh;
  assign mdioOut = bbEnR ? bbData : (strb.busy && txShift[SHIFT_W-1]);
  assign mdioOe  = bbEnR ? bbOe   : engOe;
  assign irq     = |(pollChanged & ~maskReg);

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (frameWrReq && strb.busy && !strb.finish) |=> $stable(frameReg)); // R5
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !curPoll) |=> frameReg[16]); // R4
  AST_CHANGED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pollDone && !clearRd) |=> $stable(pollChanged)); // R8
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (clearRd && !pollDone) |=> (pollChanged == '0)); // R9
  AST_BASIC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pollDone |=> $stable(pollBasic)); // R7
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        mdioIn0,
  input  logic        mdioIn1,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic        irq
);
  mdioStrobes_t strb;
  logic frameWrReq, pollReq, bbEn;

  mdio_mgmt_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .frameWrReq(frameWrReq), .pollReq(pollReq),
    .bbEn(bbEn), .strb(strb)
  );

  mdio_mgmt_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .mdioIn0(mdioIn0), .mdioIn1(mdioIn1), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .irq(irq), .frameWrReq(frameWrReq), .pollReq(pollReq),
    .bbEn(bbEn)
  );
endmodule

// File: tb/tb_mdio_mgmt_engine.sv
module tb_mdio_mgmt_engine;
  localparam int HALF   = 2;
  localparam int BITC   = 2 * HALF;
  localparam int FRAMEC = 64 * BITC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic mdioIn0 = 1'b1, mdioIn1 = 1'b1;
  logic mdc, mdioOut, mdioOe, irq;

  always #5 clk = ~clk;

  mdio_mgmt_engine #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdioIn0(mdioIn0),
    .mdioIn1(mdioIn1), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .irq(irq)
  );

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  bit mRun = 0, mRead = 0, mPoll = 0;
  int mT = 0;
  logic [31:0] mWord = 0;
  logic [15:0] resp = 0, phyData = 0;
  int pollCnt = 0, frameCnt = 0;
  bit mPollEn = 0, mBb = 0, mSel = 0, mBbClk = 0, mBbD = 0, mBbOe = 0;
  logic [4:0] mPr = 0, mPd = 0;
  bit forceOn = 0;
  logic [1:0] forceVal = 2'b11;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mT = 0; mPollEn = 0; mBb = 0; mSel = 0;
      mBbClk = 0; mBbD = 0; mBbOe = 0; mPr = 0; mPd = 0;
    end else begin
      if (!mRun) begin
        if (regWr && regAddr == 3'd0 && !mBb) begin
          mRun = 1; mT = 0; mWord = regWdata; mPoll = 0;
          mRead = (regWdata[29:28] == 2'b10); resp = phyData;
        end else if (mPollEn && !mBb) begin
          mRun = 1; mT = 0; mPoll = 1; mRead = 1; resp = phyData;
          mWord = {2'b01, 2'b10, mPd, mPr, 2'b10, 16'h0};
        end
      end else begin
        mT++;
        if (mT == FRAMEC) begin
          mRun = 0;
          if (mPoll) pollCnt++; else frameCnt++;
        end
      end
      if (regWr) begin
        case (regAddr)
          3'd1: begin
            mSel = regWdata[0]; mPollEn = regWdata[1]; mBb = regWdata[2];
            mPr = regWdata[7:3]; mPd = regWdata[14:10];
          end
          3'd4: mBbClk = regWdata[0];
          3'd5: mBbD = regWdata[0];
          3'd6: mBbOe = regWdata[0];
          default: ;
        endcase
      end
    end
  end

  // PHY responder and per-clock pin comparison
  always @(negedge clk) begin
    int bitN;
    logic lvl, eMdc, eOut, eOe;
    bitN = mT / BITC;
    if (forceOn) begin
      mdioIn0 <= forceVal[0];
      mdioIn1 <= forceVal[1];
    end else if (mRun && mRead && bitN >= 47) begin
      lvl = (bitN == 47) ? 1'b0 : resp[15 - (bitN - 48)];
      mdioIn0 <= mSel ? ~lvl : lvl;
      mdioIn1 <= mSel ? lvl : ~lvl;
    end else begin
      mdioIn0 <= 1'b1;
      mdioIn1 <= 1'b1;
    end
    if (rstN) begin
      if (mBb) begin
        eMdc = mBbClk; eOut = mBbD; eOe = mBbOe;
      end else if (mRun) begin
        eMdc = (mT % BITC) >= HALF;
        eOut = (bitN < 32) ? 1'b1 : mWord[63 - bitN];
        eOe  = !(mRead && bitN >= 46);
      end else begin
        eMdc = 0; eOut = 0; eOe = 0;
      end
      if (mBb) chk("R11 pins", {29'd0, mdc, mdioOut, mdioOe}, {29'd0, eMdc, eOut, eOe});
      else begin
        chk("R1 mdc/mdio", {30'd0, mdc, mdioOut}, {30'd0, eMdc, eOut});
        chk("R2 oe", {31'd0, mdioOe}, {31'd0, eOe});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a; regRd = (a == 3'd3);
    #1 chk(tag, regRdata, exp);
    @(negedge clk);
    regRd = 0;
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = frameCnt + n;
    while (frameCnt < target) @(negedge clk);
  endtask

  task automatic waitPolls(input int n);
    int target;
    target = pollCnt + n;
    while (pollCnt < target) @(negedge clk);
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] wf, rf;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R12 reset values
    rdchk("R12 frame", 3'd0, 32'h0);
    rdchk("R12 cfg", 3'd1, 32'h0000_0300);
    rdchk("R12 mask", 3'd2, 32'h0000_FFFF);
    rdchk("R12 bbdata", 3'd5, 32'h0);
    chk("R12 irq", {31'd0, irq}, 32'd0);
    rdchk("R12 status", 3'd3, 32'h0);

    // R1/R4/R5 write frame, busy write ignored
    wf = {2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'hA5C3};
    wr(3'd0, wf);
    rdchk("R4 bit16 clear while busy", 3'd0, wf);
    wr(3'd0, 32'h6FFF_0000);
    rdchk("R5 frame write during frame ignored", 3'd0, wf);
    waitFrames(1);
    rdchk("R4 write frame done", 3'd0, wf | 32'h0001_0000);

    // R3 read frame on line 0
    phyData = 16'h1234;
    rf = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0};
    wr(3'd0, rf);
    waitFrames(1);
    rdchk("R3 read line0", 3'd0, rf | 32'h0001_1234);

    // R3 read frame on line 1
    wr(3'd1, 32'h1);
    phyData = 16'hBEEF;
    wr(3'd0, rf);
    waitFrames(1);
    rdchk("R3 read line1", 3'd0, rf | 32'h0001_BEEF);

    // R6 live line levels
    forceOn = 1; forceVal = 2'b01;
    repeat (2) @(negedge clk);
    rdchk("R6 line levels 01", 3'd1, 32'h0000_0101);
    forceVal = 2'b10;
    repeat (2) @(negedge clk);
    rdchk("R6 line levels 10", 3'd1, 32'h0000_0201);
    forceOn = 0;

    // R7/R8 polling
    phyData = 16'h00F0;
    wr(3'd1, 32'h2 | (32'd7 << 3) | (32'd9 << 10));
    waitPolls(1);
    rdchk("R8 first poll no change", 3'd3, 32'h00F0_0000);
    phyData = 16'h00F3;
    waitPolls(2);
    chk("R10 masked change no irq", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h0000_FFFE);
    @(negedge clk);
    chk("R10 unmasked change irq", {31'd0, irq}, 32'd1);
    rdchk("R7 basic and changed", 3'd3, 32'h00F3_0003);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    rdchk("R9 changed cleared", 3'd3, 32'h00F3_0000);
    phyData = 16'h00F1;
    waitPolls(2);
    phyData = 16'h80F1;
    waitPolls(2);
    chk("R10 change only on masked bits", {31'd0, irq}, 32'd0);
    rdchk("R8 accumulate", 3'd3, 32'h80F1_8002);

    // R5 frame write during poll
    while (!(mRun && mT < 100)) @(negedge clk);
    wr(3'd0, wf);
    rdchk("R5 frame write during poll ignored", 3'd0, rf | 32'h0001_BEEF);
    wr(3'd1, 32'h0);
    while (mRun) @(negedge clk);

    // R11 bit-bang
    wr(3'd1, 32'h4);
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h1);
    wr(3'd6, 32'h1);
    @(negedge clk);
    chk("R11 bit-bang pins high", {29'd0, mdc, mdioOut, mdioOe}, 32'h7);
    wr(3'd0, wf);
    repeat (10) @(negedge clk);
    rdchk("R5 frame write in bit-bang ignored", 3'd0, rf | 32'h0001_BEEF);
    wr(3'd5, 32'h0);
    @(negedge clk);
    chk("R11 bit-bang data low", {31'd0, mdioOut}, 32'd0);
    wr(3'd1, 32'h0);
    repeat (4) @(negedge clk);
    chk("R1 idle pins", {29'd0, mdc, mdioOut, mdioOe}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule